// File: doc/BRIEF.md
# Double-Buffered Input Capture Channel

This block is one input-capture channel for a free-running timer. When a qualified event pulse arrives, the channel records the timer's current count as a timestamp. Two registers hold the timestamps. The readable head register is the one software sees. Behind it sits a hidden tail register that software cannot reach. Together they act as a two-entry FIFO. A value in the tail moves to the head as soon as the head is empty or is being read. The tail can never be observed directly.

Captured data leaves the block on a valid/ready stream. `cap_valid_o` is high while the head register holds an unread timestamp, and it doubles as the channel's request flag for an interrupt, DMA or event. A transfer takes place on a rising clock edge where `cap_valid_o` and `cap_ready_i` are both high. While `cap_ready_i` stays low, the consumer is holding off, and the head value and valid are held unchanged. Upstream there is no back-pressure: an event that finds both stages full is dropped, and a sticky error flag is raised. The enables, event input and error clear are plain control pins. The event input is a single-cycle pulse that is already synchronous to `clk_i`.

Top module: `incap_channel`

## Requirements
- R1: After reset, `cap_valid_o` is 0 and `err_o` is 0.
- R2: An event pulse is accepted only in a cycle where `evt_en_i` and `cap_en_i` are both 1; otherwise it changes neither the stored data nor `err_o`.
- R3: The stored timestamp equals `count_i` in the cycle the accepted event is high.
- R4: An accepted event into an empty channel shows up on `cap_data_o` with `cap_valid_o`=1 one cycle later, and the tail stays empty, so one further event is stored without error.
- R5: While `cap_valid_o`=1 and `cap_ready_i`=0, `cap_valid_o` stays 1 and `cap_data_o` keeps its value.
- R6: Timestamps leave in arrival order; after a transfer with a value waiting in the tail, that value appears on `cap_data_o` the next cycle and `cap_valid_o` stays 1.
- R7: After a transfer with the tail empty and no accepted event, `cap_valid_o` is 0 the next cycle.
- R8: An accepted event while both stages are full and no transfer occurs is discarded, the stored values are unchanged, and `err_o` is 1 from the next cycle.
- R9: An accepted event in the same cycle as a transfer is handled read-first: it is stored, nothing is lost, and no error is raised.
- R10: `err_o` stays 1 until a cycle with `err_clr_i`=1 and no new overflow clears it; if an overflow and a clear coincide, `err_o` remains 1.
- R11: `cap_ready_i`=1 while `cap_valid_o`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Current timer count |
| evt_i | input | 1 | Single-cycle event pulse |
| evt_en_i | input | 1 | Event input enable |
| cap_en_i | input | 1 | Capture enable |
| cap_ready_i | input | 1 | Consumer ready; a transfer happens when this and cap_valid_o are both 1 |
| cap_valid_o | output | 1 | Head register holds unread data; also the request flag |
| cap_data_o | output | CNT_W | Head timestamp |
| err_o | output | 1 | Sticky overflow flag |
| err_clr_i | input | 1 | Clear strobe for err_o (write-one-to-clear) |

## Verification
On every cycle, the assertions check these rules:
- a held head under back-pressure keeps its value (R5);
- the tail is never full while the head is empty (R6);
- a read-first refill keeps both stages occupied (R9);
- a disabled channel stays empty (R2);
- a ready with nothing to send changes nothing (R11);
- the error flag sets after an overflow and stays set (R8, R10).

Some properties can only be shown by the bench's scenarios, where a scoreboard compares the data stream with the queue of expected timestamps:
- the exact timestamp values (R3);
- the arrival order through the two stages (R6);
- that an overflowing stamp is really absent from the output stream (R8);
- the behaviour when a clear and an overflow coincide (R10).

// File: rtl/incap_pkg.sv
package incap_pkg;
  // Action chosen by the two-stage store in one cycle
  typedef enum logic [2:0] {
    ACT_HOLD,        // nothing enters; head may empty on a read
    ACT_LOAD_HEAD,   // new stamp goes straight to the free head
    ACT_LOAD_TAIL,   // head busy, stamp parks in the tail
    ACT_SHIFT,       // tail moves forward, tail empties
    ACT_SHIFT_FILL,  // tail moves forward, new stamp refills tail
    ACT_DROP         // both full, no read: stamp discarded
  } store_act_e;
endpackage

// File: rtl/incap_gate.sv
module incap_gate #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             evt_i,
  input  logic             evt_en_i,
  input  logic             cap_en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             take_o,
  output logic [CNT_W-1:0] stamp_o
);
  // Qualify the pulse; the stamp is the count in the event cycle
  always_comb begin
    take_o  = evt_i & evt_en_i & cap_en_i;
    stamp_o = count_i;
  end
endmodule

// File: rtl/incap_store.sv
module incap_store
  import incap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] stamp_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] head_o,
  output logic             head_vld_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] head_q, tail_q;
  logic             head_v_q, tail_v_q;
  logic             head_free;
  store_act_e       act;

  assign head_free = ~head_v_q | pop_i;

  always_comb begin
    act = ACT_HOLD;
    if (head_free) begin
      if (tail_v_q) act = take_i ? ACT_SHIFT_FILL : ACT_SHIFT;
      else if (take_i) act = ACT_LOAD_HEAD;
    end else if (take_i) begin
      act = tail_v_q ? ACT_DROP : ACT_LOAD_TAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      tail_q   <= '0;
      head_v_q <= 1'b0;
      tail_v_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD_HEAD: begin
          head_q   <= stamp_i;
          head_v_q <= 1'b1;
        end
        ACT_LOAD_TAIL: begin
          tail_q   <= stamp_i;
          tail_v_q <= 1'b1;
        end
        ACT_SHIFT: begin
          head_q   <= tail_q;
          head_v_q <= 1'b1;
          tail_v_q <= 1'b0;
        end
        ACT_SHIFT_FILL: begin
          head_q   <= tail_q;
          head_v_q <= 1'b1;
          tail_q   <= stamp_i;
          tail_v_q <= 1'b1;
        end
        ACT_DROP: ;
        default: if (head_free) head_v_q <= 1'b0;
      endcase
    end
  end

  assign head_o     = head_q;
  assign head_vld_o = head_v_q;
  assign ovf_o      = (act == ACT_DROP);

  // R6: the tail never holds data while the head is empty
  p_tail_needs_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_v_q |-> head_v_q);
  // R5: an unread head is held while the consumer stalls
  p_head_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_v_q && !pop_i |=> head_v_q && $stable(head_q));
  // R9: a read with a full tail and a new stamp keeps both stages full
  p_read_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && take_i && tail_v_q |=> head_v_q && tail_v_q);
endmodule

// File: rtl/incap_errflag.sv
module incap_errflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= set_i | (err_q & ~clr_i);
  end

  assign err_o = err_q;

  // R8: an overflow is always reported the next cycle
  p_err_on_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);
  // R10: the flag only leaves the set state through a clear
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q);
endmodule

// File: rtl/incap_channel.sv
module incap_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             evt_i,
  input  logic             evt_en_i,
  input  logic             cap_en_i,
  input  logic             cap_ready_i,
  output logic             cap_valid_o,
  output logic [CNT_W-1:0] cap_data_o,
  output logic             err_o,
  input  logic             err_clr_i
);
  logic             take;
  logic [CNT_W-1:0] stamp;
  logic             pop;
  logic             ovf;
  logic             head_vld;

  assign pop = head_vld & cap_ready_i;

  incap_gate #(.CNT_W(CNT_W)) u_gate (
    .evt_i    (evt_i),
    .evt_en_i (evt_en_i),
    .cap_en_i (cap_en_i),
    .count_i  (count_i),
    .take_o   (take),
    .stamp_o  (stamp)
  );

  incap_store #(.CNT_W(CNT_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .stamp_i    (stamp),
    .pop_i      (pop),
    .head_o     (cap_data_o),
    .head_vld_o (head_vld),
    .ovf_o      (ovf)
  );

  incap_errflag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf),
    .clr_i  (err_clr_i),
    .err_o  (err_o)
  );

  assign cap_valid_o = head_vld;

  // R2: a channel that is not fully enabled stays empty
  p_disabled_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_en_i && cap_en_i) && !cap_valid_o |=> !cap_valid_o);
  // R11: ready without data and without an event changes nothing
  p_idle_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_valid_o && cap_ready_i && !evt_i |=> !cap_valid_o);
endmodule

// File: tb/test_incap_channel.sv
module test_incap_channel;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          evt = 1'b0, een = 1'b0, cen = 1'b0, rdy = 1'b0, clr = 1'b0;
  logic          vld, err;
  logic [CW-1:0] dat;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [CW-1:0] exp_q[$];
  logic          m_err = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  incap_channel #(.CNT_W(CW)) i_incap_channel (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .evt_i(evt),
    .evt_en_i(een), .cap_en_i(cen), .cap_ready_i(rdy),
    .cap_valid_o(vld), .cap_data_o(dat), .err_o(err), .err_clr_i(clr)
  );

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // One cycle of stimulus; inputs change just after a rising edge
  task automatic step(input logic e, input logic r, input logic c);
    evt = e; rdy = r; clr = c;
    @(posedge clk); #1;
    evt = 1'b0; rdy = 1'b0; clr = 1'b0;
  endtask

  // Monitor / scoreboard: compares state, then applies this cycle's inputs
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      m_err = 1'b0;
    end else if (!done) begin
      logic pop, take, ovf;
      check("R5 valid", {15'd0, vld}, {15'd0, exp_q.size() > 0});
      if (exp_q.size() > 0) check("R3/R6 data", dat, exp_q[0]);
      check("R8/R10 err", {15'd0, err}, {15'd0, m_err});
      pop  = (exp_q.size() > 0) && rdy;
      take = evt && een && cen;
      ovf  = 1'b0;
      if (pop) void'(exp_q.pop_front());
      if (take) begin
        if (exp_q.size() < 2) exp_q.push_back(cnt);
        else ovf = 1'b1;
      end
      m_err = ovf | (m_err & ~clr);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", {15'd0, vld}, 16'd0);
    check("R1 err", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R2: partially enabled channel ignores events
    een = 1'b0; cen = 1'b1; step(1, 0, 0); step(0, 0, 0);
    een = 1'b1; cen = 1'b0; step(1, 0, 0); step(0, 0, 0);
    check("R2 valid", {15'd0, vld}, 16'd0);
    check("R2 err", {15'd0, err}, 16'd0);
    cen = 1'b1;
    // R11: ready while empty
    step(0, 1, 0); step(0, 1, 0);
    check("R11 valid", {15'd0, vld}, 16'd0);
    // R4 then R7: single capture, then read drains
    step(1, 0, 0);
    check("R4 valid", {15'd0, vld}, 16'd1);
    step(0, 0, 0); step(0, 0, 0);
    step(0, 1, 0);
    check("R7 valid", {15'd0, vld}, 16'd0);
    // R4/R6: two captures, no error, in order
    step(1, 0, 0); step(1, 0, 0);
    check("R4 err", {15'd0, err}, 16'd0);
    step(0, 1, 0);
    check("R6 valid", {15'd0, vld}, 16'd1);
    step(0, 1, 0); step(0, 0, 0);
    // R8: third capture overflows; R10 sticky
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R8 err", {15'd0, err}, 16'd1);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    check("R10 sticky", {15'd0, err}, 16'd1);
    // R10: overflow and clear together keep the flag
    step(1, 0, 1);
    check("R10 set wins", {15'd0, err}, 16'd1);
    step(0, 0, 1);
    check("R10 clear", {15'd0, err}, 16'd0);
    // R9: event with read while full
    step(1, 1, 0);
    check("R9 err", {15'd0, err}, 16'd0);
    check("R9 valid", {15'd0, vld}, 16'd1);
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);
    check("R7 drained", {15'd0, vld}, 16'd0);
    // Mixed traffic, scoreboard checks every cycle
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[9:6] == 4'd0) een = ~een;
      step(lf[0], lf[1] & lf[2], lf[3] & lf[4] & lf[5]);
    end
    een = 1'b1;
    repeat (4) step(0, 1, 1);
    check("R7 final", {15'd0, vld}, 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule